// File: doc/BRIEF.md
# Bit-Clearing Programmable Byte Store

This block is a clocked, synthesizable model of a one-time-programmable byte memory as it appears at its device pins. A 13-bit address selects one of 8192 bytes. Two active-low enables control whether the data pins are driven. An active-low program strobe writes a byte. A programming-supply flag separates normal operation from programming operation. A second flag, which stands for a high voltage on address bit 9, switches reads from the array to a fixed two-byte identification code. The bidirectional data pins are split into a data input, a data output and an output-drive enable.

The mode is decoded from the enables, the strobe and the supply flag:

| Mode | Controls | Data pins |
|---|---|---|
| standby | chip enable high | released |
| inhibit | chip enable high, supply flag high | released |
| output disable | output enable high | released |
| read | both enables low, strobe high | array byte |
| verify | as read, supply flag high | array byte |
| program | supply flag high, chip enable low, output enable high | released |

Programming can only clear bits. A rising strobe edge in program mode merges the data input into the stored byte with a bitwise AND. The only way back to all ones is the erase command. It rewrites every location to all ones, one location per clock, and reset starts the same sweep.

Reads are registered. The output and its drive enable show the state of the inputs that were present two clock edges earlier.

Top module: `otp_array_ctl`

## Requirements
- R1: After reset, and after a one-cycle pulse on `erase_all` once its sweep of 8192 cycles has ended, every location reads 0xFF.
- R2: With `ce_n`=0, `oe_n`=0 and `pgm_n`=1, `dout_en` is 1 and `dout` carries the addressed byte. Both change two clock edges after their inputs.
- R3: With `ce_n`=1, `dout_en` is 0 whatever the values of `oe_n`, `pgm_n`, `vpp_hi` and `id_hv`.
- R4: With `ce_n`=0 and `oe_n`=1, `dout_en` is 0.
- R5: A low-to-high transition of `pgm_n` is a program pulse. If it occurs while `vpp_hi`=1, `ce_n`=0 and `oe_n`=1, the addressed byte becomes its old value ANDed with `din`.
- R6: A program pulse has no effect on the stored byte if `vpp_hi`=0, or if `ce_n`=1 (inhibit).
- R7: With `vpp_hi`=1, `ce_n`=0, `oe_n`=0 and `pgm_n`=1, the outputs drive the stored byte, exactly as in a read.
- R8: With `id_hv`=1 and reads enabled, `dout` is 0x8F when `addr[0]`=0 and 0xC2 when `addr[0]`=1.
- R9: While an erase sweep runs, `dout_en` is 0 and program pulses are discarded.
- R10: A program pulse with `din`=0xFF leaves the stored byte unchanged. A cleared bit is never set again by programming.
- R11: With `ce_n`=0, `oe_n`=0 and `pgm_n`=0, `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts an erase sweep |
| addr | input | 13 | Byte address; bit 0 selects the identification byte |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low; sampled through a synchronizer |
| vpp_hi | input | 1 | Programming supply is at its high level |
| id_hv | input | 1 | Identification high voltage is present on address bit 9 |
| erase_all | input | 1 | Starts a sweep that sets every byte to 0xFF |
| din | input | 8 | Byte applied to the data pins during programming |
| dout | output | 8 | Byte driven onto the data pins |
| dout_en | output | 1 | Data pins are driven |

## Verification
A corrupted bit in the array, or a faulty read-modify-write merge, does not show at the pins until that location is read back. The bench therefore reads every programmed address after each pulse, two clock edges later. A mode decode that wrongly sets the drive enable shows within two cycles as a driven bus in standby, output-disable or strobe-low conditions. A sequencer stuck in the erase state shows as a bus that never drives. A sequencer that leaves the sweep too early leaves locations above the stop point unerased, and a read of the top address after the sweep exposes it.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    OM_STANDBY,
    OM_INHIBIT,
    OM_OUT_OFF,
    OM_READ,
    OM_VERIFY,
    OM_PROGRAM,
    OM_ILLEGAL
  } otp_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ERASE,
    SQ_FETCH,
    SQ_MERGE
  } otp_seq_e;

  localparam logic [7:0] OTP_MAKER_BYTE  = 8'h8F;
  localparam logic [7:0] OTP_DEVICE_BYTE = 8'hC2;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
(
  input  logic ce_n,
  input  logic oe_n,
  input  logic pgm_n,
  input  logic vpp_hi,
  output logic drive_ok,
  output logic prog_ok
);

  otp_mode_e mode;

  always_comb begin
    if (ce_n) begin
      mode = vpp_hi ? OM_INHIBIT : OM_STANDBY;
    end else if (oe_n) begin
      mode = vpp_hi ? OM_PROGRAM : OM_OUT_OFF;
    end else if (!pgm_n) begin
      mode = OM_ILLEGAL;
    end else begin
      mode = vpp_hi ? OM_VERIFY : OM_READ;
    end
  end

  always_comb begin
    drive_ok = 1'b0;
    prog_ok  = 1'b0;
    case (mode)
      OM_READ, OM_VERIFY: drive_ok = 1'b1;
      OM_PROGRAM:         prog_ok  = 1'b1;
      default: begin
        drive_ok = 1'b0;
        prog_ok  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/otp_strobe_sync.sv
module otp_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic rise
);

  logic [SYNC_STAGES:0] shreg;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      always_ff @(posedge clk) begin
        if (rst) shreg <= '1;
        else     shreg <= strobe_n;
      end
      assign rise = strobe_n & ~shreg[0];
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) shreg <= '1;
        else     shreg <= {shreg[SYNC_STAGES-1:0], strobe_n};
      end
      assign rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
    end
  endgenerate

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
    rd_data <= cells[rd_addr];
  end

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase_req,
  input  logic              pgm_rise,
  input  logic              prog_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              use_cap,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              wr_en,
  output logic              prog_wr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  otp_seq_e          state;
  logic [ADDR_W-1:0] sweep;
  logic [DATA_W-1:0] cap_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_ERASE;
      sweep    <= '0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (erase_req) begin
            state <= SQ_ERASE;
            sweep <= '0;
          end else if (pgm_rise && prog_ok) begin
            state    <= SQ_FETCH;
            cap_addr <= addr;
            cap_data <= din;
          end
        end
        SQ_ERASE: begin
          if (sweep == LAST_ADDR) state <= SQ_IDLE;
          sweep <= sweep + 1'b1;
        end
        SQ_FETCH: begin
          if (erase_req) begin
            state <= SQ_ERASE;
            sweep <= '0;
          end else begin
            state <= SQ_MERGE;
          end
        end
        SQ_MERGE: begin
          if (erase_req) begin
            state <= SQ_ERASE;
            sweep <= '0;
          end else begin
            state <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    busy    = (state != SQ_IDLE);
    use_cap = (state == SQ_FETCH) || (state == SQ_MERGE);
    prog_wr = (state == SQ_MERGE) && !erase_req;
    wr_en   = (state == SQ_ERASE) || prog_wr;
    if (state == SQ_ERASE) begin
      wr_addr = sweep;
      wr_data = '1;
    end else begin
      wr_addr = cap_addr;
      wr_data = rd_data & cap_data;
    end
  end

endmodule

// File: rtl/otp_array_ctl.sv
module otp_array_ctl
  import otp_pkg::*;
#(
  parameter int          ADDR_W      = 13,
  parameter int          DATA_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  MAKER_BYTE  = OTP_MAKER_BYTE,
  parameter logic [7:0]  DEVICE_BYTE = OTP_DEVICE_BYTE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic              erase_all,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic              drive_ok;
  logic              prog_ok;
  logic              pgm_rise;
  logic              seq_busy;
  logic              seq_use_cap;
  logic              seq_prog_wr;
  logic              arr_wr_en;
  logic [ADDR_W-1:0] cap_addr;
  logic [ADDR_W-1:0] arr_wr_addr;
  logic [DATA_W-1:0] arr_wr_data;
  logic [ADDR_W-1:0] arr_rd_addr;
  logic [DATA_W-1:0] arr_rd_data;

  logic              drive_q;
  logic              id_q;
  logic              idsel_q;

  otp_mode_decode u_decode (
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .pgm_n    (pgm_n),
    .vpp_hi   (vpp_hi),
    .drive_ok (drive_ok),
    .prog_ok  (prog_ok)
  );

  otp_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (pgm_n),
    .rise     (pgm_rise)
  );

  otp_prog_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .erase_req (erase_all),
    .pgm_rise  (pgm_rise),
    .prog_ok   (prog_ok),
    .addr      (addr),
    .din       (din),
    .rd_data   (arr_rd_data),
    .busy      (seq_busy),
    .use_cap   (seq_use_cap),
    .cap_addr  (cap_addr),
    .wr_en     (arr_wr_en),
    .prog_wr   (seq_prog_wr),
    .wr_addr   (arr_wr_addr),
    .wr_data   (arr_wr_data)
  );

  assign arr_rd_addr = seq_use_cap ? cap_addr : addr;

  otp_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .wr_en   (arr_wr_en),
    .wr_addr (arr_wr_addr),
    .wr_data (arr_wr_data),
    .rd_addr (arr_rd_addr),
    .rd_data (arr_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
      id_q    <= 1'b0;
      idsel_q <= 1'b0;
      dout_en <= 1'b0;
      dout    <= '0;
    end else begin
      drive_q <= drive_ok && !seq_busy;
      id_q    <= id_hv;
      idsel_q <= addr[0];
      dout_en <= drive_q;
      if (!drive_q)     dout <= '0;
      else if (!id_q)   dout <= arr_rd_data;
      else if (idsel_q) dout <= DATA_W'(DEVICE_BYTE);
      else              dout <= DATA_W'(MAKER_BYTE);
    end
  end

endmodule

// File: rtl/otp_array_chk.sv
module otp_array_chk #(
  parameter int         ADDR_W      = 13,
  parameter int         DATA_W      = 8,
  parameter logic [7:0] MAKER_BYTE  = 8'h8F,
  parameter logic [7:0] DEVICE_BYTE = 8'hC2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pgm_n,
  input logic              vpp_hi,
  input logic              id_hv,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              busy,
  input logic              prog_wr
);

  // R2, R3, R4, R11: the bus is driven only if both enables were low and the strobe was high
  a_r2_drive_needs_enables: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> (!$past(ce_n, 2) && !$past(oe_n, 2) && $past(pgm_n, 2)));

  // R9: no drive while the sequencer is busy
  a_r9_quiet_while_busy: assert property (@(posedge clk) disable iff (rst)
    $past(busy, 2) |-> !dout_en);

  // R5, R6: a program write follows an accepted pulse in program mode only
  a_r6_write_needs_supply: assert property (@(posedge clk) disable iff (rst)
    prog_wr |-> ($past(vpp_hi, 2) && !$past(ce_n, 2) && $past(oe_n, 2)));

  // R8: the identification bytes
  a_r8_maker_byte: assert property (@(posedge clk) disable iff (rst)
    (dout_en && $past(id_hv, 2) && !$past(addr[0], 2)) |-> (dout == DATA_W'(MAKER_BYTE)));

  a_r8_device_byte: assert property (@(posedge clk) disable iff (rst)
    (dout_en && $past(id_hv, 2) && $past(addr[0], 2)) |-> (dout == DATA_W'(DEVICE_BYTE)));

  // R3: an undriven bus carries zero
  a_r3_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> (dout == '0));

endmodule

bind otp_array_ctl otp_array_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .MAKER_BYTE(MAKER_BYTE), .DEVICE_BYTE(DEVICE_BYTE)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .ce_n    (ce_n),
  .oe_n    (oe_n),
  .pgm_n   (pgm_n),
  .vpp_hi  (vpp_hi),
  .id_hv   (id_hv),
  .dout    (dout),
  .dout_en (dout_en),
  .busy    (seq_busy),
  .prog_wr (seq_prog_wr)
);

// File: tb/otp_array_ctl_test.sv
module otp_array_ctl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] addr = '0;
  logic        ce_n = 1'b1;
  logic        oe_n = 1'b1;
  logic        pgm_n = 1'b1;
  logic        vpp_hi = 1'b0;
  logic        id_hv = 1'b0;
  logic        erase_all = 1'b0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  otp_array_ctl uut (
    .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .pgm_n(pgm_n), .vpp_hi(vpp_hi), .id_hv(id_hv), .erase_all(erase_all),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual en/data=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // returns {dout_en, dout} for the given pin state
  task automatic look(input logic [12:0] a, input logic c, input logic o,
                      input logic p, input logic v, input logic idf,
                      output logic [8:0] res);
    @(negedge clk);
    addr = a; ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; id_hv = idf;
    settle();
    res = {dout_en, dout};
    ce_n = 1'b1; oe_n = 1'b1; id_hv = 1'b0; vpp_hi = 1'b0; pgm_n = 1'b1;
  endtask

  task automatic read_byte(input logic [12:0] a, input string req, input logic [7:0] exp);
    logic [8:0] r;
    look(a, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, r);
    check(req, r, {1'b1, exp});
  endtask

  task automatic pulse(input logic [12:0] a, input logic [7:0] d,
                       input logic v, input logic c);
    @(negedge clk);
    addr = a; din = d; vpp_hi = v; ce_n = c; oe_n = 1'b1; pgm_n = 1'b1;
    repeat (2) @(negedge clk);
    pgm_n = 1'b0;
    repeat (3) @(negedge clk);
    pgm_n = 1'b1;
    repeat (8) @(negedge clk);
    vpp_hi = 1'b0; ce_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 reset drive", {dout_en, 8'h00}, 9'h000);
    repeat (8300) @(negedge clk);
    read_byte(13'h0000, "R1 erased low", 8'hFF);
    read_byte(13'h1FFF, "R1 erased top", 8'hFF);
    read_byte(13'h0AAA, "R2 erased mid", 8'hFF);
  endtask

  task automatic t_program();
    pulse(13'h0010, 8'hA5, 1'b1, 1'b0);
    read_byte(13'h0010, "R5 first pulse", 8'hA5);
    read_byte(13'h0011, "R2 neighbour", 8'hFF);
    pulse(13'h0010, 8'h3C, 1'b1, 1'b0);
    read_byte(13'h0010, "R5 and merge", 8'h24);
    pulse(13'h0010, 8'hFF, 1'b1, 1'b0);
    read_byte(13'h0010, "R10 ones keep", 8'h24);
  endtask

  task automatic t_ignored();
    pulse(13'h0020, 8'h00, 1'b0, 1'b0);
    read_byte(13'h0020, "R6 low supply", 8'hFF);
    pulse(13'h0020, 8'h00, 1'b1, 1'b1);
    read_byte(13'h0020, "R6 inhibit", 8'hFF);
  endtask

  task automatic t_hiz();
    logic [8:0] r;
    look(13'h0010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, r);
    check("R3 standby", {r[8], 8'h00}, 9'h000);
    look(13'h0010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, r);
    check("R3 inhibit id", {r[8], 8'h00}, 9'h000);
    look(13'h0010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, r);
    check("R4 out off", {r[8], 8'h00}, 9'h000);
    look(13'h0010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, r);
    check("R11 strobe low", {r[8], 8'h00}, 9'h000);
  endtask

  task automatic t_verify_id();
    logic [8:0] r;
    look(13'h0010, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, r);
    check("R7 verify", r, {1'b1, 8'h24});
    look(13'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, r);
    check("R8 maker", r, {1'b1, 8'h8F});
    look(13'h0001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, r);
    check("R8 device", r, {1'b1, 8'hC2});
  endtask

  task automatic t_erase();
    logic [8:0] r;
    @(negedge clk);
    erase_all = 1'b1;
    @(negedge clk);
    erase_all = 1'b0;
    look(13'h0010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, r);
    check("R9 busy quiet", {r[8], 8'h00}, 9'h000);
    pulse(13'h0030, 8'h00, 1'b1, 1'b0);
    repeat (8300) @(negedge clk);
    read_byte(13'h0010, "R1 re-erased", 8'hFF);
    read_byte(13'h0030, "R9 pulse dropped", 8'hFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_program();
    t_ignored();
    t_hiz();
    t_verify_id();
    t_erase();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule